// File: doc/BRIEF.md
# Tiled Frame Read Command Generator

This block turns a rectangular tile request into a stream of encoded DRAM command words for reading that tile out of a frame held in DDR3 memory. The caller supplies a start row and start column, the frame-line increment, the tile height and the tile width as a count of 16-byte columns minus one, then pulses `start`. The block emits one 32-bit command word per clock with a write strobe. The words feed a downstream command sequencer that sits in front of the PHY.

Each tile line is read as a single burst of eight (16 bytes). The scan goes down a column first, one tile line after another. Each line advance adds the frame increment to a combined row/column/bank burst address that has the bank in its low bits, so the bank moves on between lines. Every access takes a fixed 8-clock slot made of ACTIVATE, pause, READ with auto-precharge, and pause. This spacing meets the activate-to-activate gap, the four-activate window and the precharge-to-activate time with no timers, provided the tile height is one of the accepted values. Heights that would break these limits are refused and flagged.

Top module: `tiled_rd_cmd_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_wr`, `busy` and `height_err` are 0 and `cmd_word` is all zero.
- R2: A start is accepted only when the height is non-zero and its value mod 8 is 0, 6 or 7. Any other height sets `height_err` in the next cycle, produces no command word and leaves `busy` low. A later accepted start clears `height_err`.
- R3: After an accepted start, every access produces four words on consecutive clocks in this order: ACTIVATE, pause, READ, pause. The first word appears two cycles after the start cycle. Both pauses carry a skip count of 2, so ACTIVATE words are 8 command clocks apart.
- R4: The word layout, from MSB down, is: address [31:17], bank [16:14], RAS/CAS/WE [13:11], DQ enable [10], DQS enable [9], buffer-read strobe [8], done [7], two zero bits [6:5] and skip count [4:0]. RAS/CAS/WE is 100 for ACTIVATE, 010 for READ and 000 for a pause. The DQ and DQS enables are always 0.
- R5: The ACTIVATE address field holds the row. The READ address field holds the column address, which is the burst column times 8, with bit 10 set for auto-precharge. Pause words carry address 0, and every word of an access carries that access's bank.
- R6: The burst address is 25 bits laid out as {row[14:0], burst column[6:0], bank[2:0]}. The first access uses {start_row, start_col, 000}. Each next line adds `row_inc`, modulo 2^25. After `height` lines, the next column starts at the previous column's first address plus 8 (one burst column with the same bank).
- R7: A tile produces height × (cols_m1+1) accesses. The done bit is 1 only on the second pause word of the last access.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle in which the done word is presented. `cmd_wr` is high only for sequence words. A `start` while `busy` is high is ignored and leaves the word stream unchanged.
- R9: `pre_act` is high in the cycle of an accepted start, and in the cycle that forms the second pause word of every access except the last. These are the cycles that load the burst address for the next ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request pulse |
| start_row | input | 15 | First row of the tile |
| start_col | input | 7 | First 16-byte burst column of the tile |
| row_inc | input | 16 | Burst-address increment from one frame line to the next |
| height | input | 6 | Tile height in lines |
| cols_m1 | input | 6 | Tile width in 16-byte columns minus one |
| cmd_word | output | 32 | Encoded command word |
| cmd_wr | output | 1 | Write strobe for `cmd_word` |
| busy | output | 1 | Sequence in progress |
| height_err | output | 1 | Last start request was refused for its height |
| pre_act | output | 1 | Burst address for the next ACTIVATE loads at the end of this cycle |

## Verification
A wrong phase counter shows up at the word level within one clock, as an out-of-order RAS/CAS/WE code or a missing skip count. A wrong burst address or line counter shows up no later than the next ACTIVATE word, at most four clocks away, as a bad row, column or bank field. The same holds when a column wraps or the address crosses the top of its range. The reference model forms every word from the tile arithmetic and checks it, together with `busy` and `pre_act`, on every clock. A refused height or an ignored start is therefore visible in the very next cycle as a stray word or a raised `busy`.

// File: rtl/tile_rd_pkg.sv
package tile_rd_pkg;

    // internal operation codes of the command field
    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_READ = 2'd1,
        OP_PRE  = 2'd2,
        OP_ACT  = 2'd3
    } op_e;

    // position inside one 8-clock access slot
    typedef enum logic [1:0] {
        PH_ACT  = 2'd0,
        PH_GAP1 = 2'd1,
        PH_READ = 2'd2,
        PH_GAP2 = 2'd3
    } phase_e;

    // encoded command word, MSB first
    typedef struct packed {
        logic [14:0] addr;
        logic [2:0]  bank;
        logic [2:0]  rcw;     // RAS, CAS, WE, positive logic
        logic        dq_en;
        logic        dqs_en;
        logic        buf_rd;
        logic        done;
        logic [1:0]  rsvd;
        logic [4:0]  skip;
    } cmd_word_t;

    function automatic logic [2:0] rcw_of(op_e op);
        case (op)
            OP_ACT:  return 3'b100;
            OP_READ: return 3'b010;
            OP_PRE:  return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    // heights whose low three bits are 1..5 break the bank-reuse timing
    function automatic logic height_ok(logic nonzero, logic [2:0] lo3);
        return nonzero && (lo3 == 3'd0 || lo3 == 3'd6 || lo3 == 3'd7);
    endfunction

endpackage

// File: rtl/tile_scan.sv
module tile_scan
    import tile_rd_pkg::*;
#(
    parameter int ROW_W   = 15,
    parameter int COLHI_W = 7,
    parameter int BANK_W  = 3,
    parameter int INC_W   = 16,
    parameter int CNT_W   = 6,
    parameter int RCB_W   = ROW_W + COLHI_W + BANK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_ok,
    input  logic [ROW_W-1:0]   start_row,
    input  logic [COLHI_W-1:0] start_col,
    input  logic [INC_W-1:0]   row_inc,
    input  logic [CNT_W-1:0]   height,
    input  logic [CNT_W-1:0]   cols_m1,
    output logic               run,
    output phase_e             phase,
    output logic [RCB_W-1:0]   cur_addr,
    output logic               last_acc,
    output logic               pre_act
);

    localparam logic [RCB_W-1:0] COL_STEP = RCB_W'(1) << BANK_W;

    logic [RCB_W-1:0] col_base;
    logic [INC_W-1:0] inc_q;
    logic [CNT_W-1:0] rows_q;
    logic [CNT_W-1:0] cols_q;
    logic [CNT_W-1:0] line_cnt;
    logic [CNT_W-1:0] col_cnt;
    logic             line_end;

    assign line_end = (line_cnt == rows_q - CNT_W'(1));
    assign last_acc = line_end && (col_cnt == cols_q);
    assign pre_act  = start_ok || (run && phase == PH_GAP2 && !last_acc);

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            phase    <= PH_ACT;
            cur_addr <= '0;
            col_base <= '0;
            inc_q    <= '0;
            rows_q   <= '0;
            cols_q   <= '0;
            line_cnt <= '0;
            col_cnt  <= '0;
        end else if (start_ok) begin
            run      <= 1'b1;
            phase    <= PH_ACT;
            cur_addr <= {start_row, start_col, BANK_W'(0)};
            col_base <= {start_row, start_col, BANK_W'(0)};
            inc_q    <= row_inc;
            rows_q   <= height;
            cols_q   <= cols_m1;
            line_cnt <= '0;
            col_cnt  <= '0;
        end else if (run) begin
            phase <= phase_e'(phase + 2'd1);
            if (phase == PH_GAP2) begin
                if (last_acc) begin
                    run <= 1'b0;
                end else if (line_end) begin
                    line_cnt <= '0;
                    col_cnt  <= col_cnt + CNT_W'(1);
                    col_base <= col_base + COL_STEP;
                    cur_addr <= col_base + COL_STEP;
                end else begin
                    line_cnt <= line_cnt + CNT_W'(1);
                    cur_addr <= cur_addr + RCB_W'(inc_q);
                end
            end
        end
    end

    // R3: the slot phase steps by one every clock of a running sequence
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (phase == phase_e'($past(phase) + 2'd1)));

    // R6: the line counter never passes the latched height
    assert_line_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run |-> (line_cnt < rows_q));

    // R9: an address load is always followed by an ACTIVATE slot
    assert_preact_next_R9: assert property (@(posedge clk) disable iff (rst)
        pre_act |=> (run && phase == PH_ACT));

endmodule

// File: rtl/cmd_pack.sv
module cmd_pack
    import tile_rd_pkg::*;
#(
    parameter int ROW_W    = 15,
    parameter int COLHI_W  = 7,
    parameter int BANK_W   = 3,
    parameter int AP_BIT   = 10,
    parameter int GAP_SKIP = 2,
    parameter int RCB_W    = ROW_W + COLHI_W + BANK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  phase_e           phase,
    input  logic [RCB_W-1:0] cur_addr,
    input  logic             last_acc,
    output logic [31:0]      cmd_word,
    output logic             cmd_wr
);

    localparam int COL_W = COLHI_W + 3;

    logic [ROW_W-1:0]   row_f;
    logic [COLHI_W-1:0] colhi_f;
    logic [BANK_W-1:0]  bank_f;
    logic [14:0]        col_addr;
    cmd_word_t          w;
    cmd_word_t          w_q;

    assign row_f   = cur_addr[RCB_W-1 -: ROW_W];
    assign colhi_f = cur_addr[BANK_W +: COLHI_W];
    assign bank_f  = cur_addr[BANK_W-1:0];

    always_comb begin
        col_addr              = '0;
        col_addr[COL_W-1:0]   = {colhi_f, 3'b000};
        col_addr[AP_BIT]      = 1'b1;
    end

    always_comb begin
        w      = '0;
        w.bank = 3'(bank_f);
        case (phase)
            PH_ACT: begin
                w.addr = 15'(row_f);
                w.rcw  = rcw_of(OP_ACT);
            end
            PH_GAP1: begin
                w.rcw  = rcw_of(OP_NOP);
                w.skip = 5'(GAP_SKIP);
            end
            PH_READ: begin
                w.addr = col_addr;
                w.rcw  = rcw_of(OP_READ);
            end
            default: begin
                w.rcw    = rcw_of(OP_NOP);
                w.skip   = 5'(GAP_SKIP);
                w.buf_rd = 1'b1;
                w.done   = last_acc;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q    <= '0;
            cmd_wr <= 1'b0;
        end else begin
            w_q    <= run ? w : '0;
            cmd_wr <= run;
        end
    end

    assign cmd_word = w_q;

    // R7: nothing is written after the done word
    assert_done_end_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && w_q.done) |=> !cmd_wr);

    // R8: a word is written only for a cycle of a running sequence
    assert_wr_source_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> $past(run));

    // R4: at most one of RAS/CAS/WE is active in any emitted word
    assert_rcw_code_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> $onehot0(w_q.rcw));

endmodule

// File: rtl/tiled_rd_cmd_gen.sv
module tiled_rd_cmd_gen
    import tile_rd_pkg::*;
#(
    parameter int ROW_W      = 15,
    parameter int COL_W      = 10,
    parameter int BANK_W     = 3,
    parameter int INC_W      = 16,
    parameter int CNT_W      = 6,
    parameter int ACT_PERIOD = 8,
    parameter int AP_BIT     = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ROW_W-1:0]   start_row,
    input  logic [COL_W-4:0]   start_col,
    input  logic [INC_W-1:0]   row_inc,
    input  logic [CNT_W-1:0]   height,
    input  logic [CNT_W-1:0]   cols_m1,
    output logic [31:0]        cmd_word,
    output logic               cmd_wr,
    output logic               busy,
    output logic               height_err,
    output logic               pre_act
);

    localparam int COLHI_W  = COL_W - 3;
    localparam int RCB_W    = ROW_W + COLHI_W + BANK_W;
    localparam int GAP_SKIP = (ACT_PERIOD - 2) / 2 - 1;

    logic             run;
    logic             start_ok;
    logic             h_good;
    phase_e           phase;
    logic [RCB_W-1:0] cur_addr;
    logic             last_acc;

    assign h_good   = height_ok(height != '0, height[2:0]);
    assign start_ok = start && !run && h_good;
    assign busy     = run;

    always_ff @(posedge clk) begin
        if (rst)
            height_err <= 1'b0;
        else if (start && !run)
            height_err <= !h_good;
    end

    tile_scan #(
        .ROW_W(ROW_W), .COLHI_W(COLHI_W), .BANK_W(BANK_W),
        .INC_W(INC_W), .CNT_W(CNT_W), .RCB_W(RCB_W)
    ) i_scan (
        .clk(clk), .rst(rst), .start_ok(start_ok),
        .start_row(start_row), .start_col(start_col), .row_inc(row_inc),
        .height(height), .cols_m1(cols_m1),
        .run(run), .phase(phase), .cur_addr(cur_addr),
        .last_acc(last_acc), .pre_act(pre_act)
    );

    cmd_pack #(
        .ROW_W(ROW_W), .COLHI_W(COLHI_W), .BANK_W(BANK_W),
        .AP_BIT(AP_BIT), .GAP_SKIP(GAP_SKIP), .RCB_W(RCB_W)
    ) i_pack (
        .clk(clk), .rst(rst), .run(run), .phase(phase),
        .cur_addr(cur_addr), .last_acc(last_acc),
        .cmd_word(cmd_word), .cmd_wr(cmd_wr)
    );

    // R2: a refused height never starts a sequence and raises the flag
    assert_bad_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !run && !h_good) |=> (!busy && height_err));

endmodule

// File: tb/test_tiled_rd_cmd_gen.sv
module test_tiled_rd_cmd_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [14:0] start_row = '0;
    logic [6:0]  start_col = '0;
    logic [15:0] row_inc = '0;
    logic [5:0]  height = '0;
    logic [5:0]  cols_m1 = '0;
    logic [31:0] cmd_word;
    logic        cmd_wr, busy, height_err, pre_act;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tiled_rd_cmd_gen i_tiled_rd_cmd_gen (
        .clk(clk), .rst(rst), .start(start), .start_row(start_row),
        .start_col(start_col), .row_inc(row_inc), .height(height),
        .cols_m1(cols_m1), .cmd_word(cmd_word), .cmd_wr(cmd_wr),
        .busy(busy), .height_err(height_err), .pre_act(pre_act)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(int addr, int bank, logic [2:0] rcw,
                                        bit bufrd, bit done, int skip);
        return {15'(addr), 3'(bank), rcw, 1'b0, 1'b0, bufrd, done, 2'b00, 5'(skip)};
    endfunction

    // R6 R7 R3 R5: behavioural list of all words of a tile
    task automatic build(int srow, int scol, int inc, int h, int m1);
        longint base;
        int total;
        int k;
        expq.delete();
        base = (longint'(srow) << 10) | (longint'(scol) << 3);
        total = h * (m1 + 1);
        k = 0;
        for (int c = 0; c <= m1; c++) begin
            for (int l = 0; l < h; l++) begin
                longint a;
                int row, colhi, bank;
                a = (base + longint'(c) * 8 + longint'(l) * inc) & ((64'd1 << 25) - 1);
                row = int'(a >> 10) & 32'h7fff;
                colhi = int'(a >> 3) & 32'h7f;
                bank = int'(a) & 7;
                expq.push_back(mk(row, bank, 3'b100, 0, 0, 0));
                expq.push_back(mk(0, bank, 3'b000, 0, 0, 2));
                expq.push_back(mk((colhi << 3) | 1024, bank, 3'b010, 0, 0, 0));
                expq.push_back(mk(0, bank, 3'b000, 1, (k == total - 1), 2));
                k++;
            end
        end
    endtask

    task automatic run_tile(int srow, int scol, int inc, int h, int m1, bit intrude);
        int n;
        build(srow, scol, inc, h, m1);
        n = expq.size();
        start_row = 15'(srow); start_col = 7'(scol); row_inc = 16'(inc);
        height = 6'(h); cols_m1 = 6'(m1); start = 1'b1;
        #1;
        check("R9", "pre_act at accepted start", pre_act, 1);
        @(negedge clk);
        start = 1'b0;
        check("R8", "busy after start", busy, 1);
        check("R3", "no word in first cycle", cmd_wr, 0);
        check("R2", "height_err cleared by good start", height_err, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            check("R3", "cmd_wr during sequence", cmd_wr, 1);
            check("R4", $sformatf("word %0d", i), cmd_word, expq[i]);
            check("R8", "busy during sequence", busy, (i < n - 1));
            check("R9", "pre_act slot", pre_act, ((i % 4) == 2) && (i / 4 < n / 4 - 1));
            if (intrude && i == 5) begin
                // R8: start while busy with different parameters must be ignored
                start = 1'b1; start_row = 15'h1234; start_col = 7'h11;
                height = 6'd3; cols_m1 = 6'd9; row_inc = 16'd1;
            end
        end
    endtask

    task automatic idle_check(string req);
        @(negedge clk);
        check(req, "idle cmd_wr", cmd_wr, 0);
        check(req, "idle busy", busy, 0);
    endtask

    task automatic bad_start(int h);
        height = 6'(h); cols_m1 = 6'd1; row_inc = 16'd9; start = 1'b1;
        #1;
        check("R2", "no pre_act on refused start", pre_act, 0);
        @(negedge clk);
        start = 1'b0;
        check("R2", $sformatf("height_err for height %0d", h), height_err, 1);
        check("R2", "busy stays low", busy, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2", "no word after refused start", cmd_wr, 0);
            check("R2", "still not busy", busy, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "cmd_wr in reset", cmd_wr, 0);
        check("R1", "busy in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "cmd_wr after reset", cmd_wr, 0);
        check("R1", "busy after reset", busy, 0);
        check("R1", "height_err after reset", height_err, 0);
        check("R1", "cmd_word after reset", cmd_word, 0);

        run_tile(100, 5, 40, 6, 0, 0);            // R3 R5 single column
        idle_check("R8");
        run_tile(3000, 20, 163, 8, 2, 1);         // R6 multi column, R8 intrusion
        idle_check("R8");
        run_tile(32767, 127, 77, 7, 1, 0);        // R6 address wrap
        idle_check("R7");

        bad_start(5);
        bad_start(1);
        bad_start(9);
        bad_start(0);
        bad_start(13);

        run_tile(7, 3, 8, 14, 0, 0);              // R2 height 14 accepted, clears flag
        run_tile(9, 0, 1, 15, 0, 0);              // R8 back-to-back start
        idle_check("R8");
        run_tile(250, 64, 321, 63, 1, 0);         // R7 tall tile
        idle_check("R7");
        run_tile(0, 0, 2, 16, 3, 0);              // R6 four columns
        idle_check("R8");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule